// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block holds the instruction address of a small microcontroller core and decides, every clock, where execution goes next. It advances sequentially, loads a jump target, enters a subroutine, resumes after a subroutine or interrupt, and takes an interrupt to a fixed vector. Return addresses are kept in a small circular stack inside the block. Software cannot address this stack.

A target is built from two parts. The low bits come from the instruction and the upper page bits come from a separate page-select input. The implemented program space is a parameter and must be a power of two. When fewer words exist than the counter can name, every computed address is folded into the implemented range, so an address beyond the end wraps around to the start.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low the address is 0000h and every stack slot holds 0000h. A return taken straight after reset therefore loads 0000h.
- R2: When `adv` is the only active strobe, the next address is the current address plus one, modulo the implemented size.
- R3: When `jump` is the highest active strobe, the next address is `{page_sel, tgt_low}` modulo the implemented size. `page_sel` forms the top 2 bits of the 13-bit address and `tgt_low` forms the low 11 bits.
- R4: `call` loads the same target as R3 and pushes the current address plus one, modulo the implemented size.
- R5: `ret` loads the most recently pushed address that has not been popped yet, and it pops that entry. Nested calls therefore unwind in last-in, first-out order.
- R6: `irq` loads 0004h and pushes the current, not yet executed address.
- R7: Priority is `irq` over `ret` over `call` over `jump` over `adv`. With no strobe active the address holds.
- R8: The stack has 8 slots and behaves as a ring. A ninth push overwrites the oldest entry. Popping beyond the pushed entries returns whatever slot the pointer reaches, with no error indication.
- R9: With 4096 implemented words, bit 12 of every address is 0. A page select of 2 or 3 therefore lands in the same place as 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv | input | 1 | Step to the next sequential address |
| jump | input | 1 | Load the target address |
| call | input | 1 | Push the return address and load the target |
| ret | input | 1 | Pop the stack into the address |
| irq | input | 1 | Push the current address and go to the interrupt vector |
| tgt_low | input | 11 | Low target bits supplied by the instruction |
| page_sel | input | 2 | Upper target bits |
| pc | output | 13 | Current instruction address |

## Verification
The bench builds two copies side by side and drives them with identical stimulus. One copy has the full 8192-word space and the other is limited to 4096 words. A sweep of more than 8192 sequential steps carries both copies through their wrap points, and jumps to every page show the folding of bit 12 in the smaller copy. Call chains ten deep, interrupts nested inside calls, and deliberate underflow pops exercise the ring behaviour of the stack in both sizes.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
   typedef enum logic [2:0] {
      ACT_HOLD = 3'd0,
      ACT_ADV  = 3'd1,
      ACT_JUMP = 3'd2,
      ACT_CALL = 3'd3,
      ACT_RET  = 3'd4,
      ACT_IRQ  = 3'd5
   } pc_act_e;
endpackage

// File: rtl/pc_arbiter.sv
module pc_arbiter
   import pc_unit_pkg::*;
(
   input  logic    adv,
   input  logic    jump,
   input  logic    call,
   input  logic    ret,
   input  logic    irq,
   output pc_act_e act
);
   // fixed priority: interrupt, return, call, jump, step
   always_comb begin
      if (irq)       act = ACT_IRQ;
      else if (ret)  act = ACT_RET;
      else if (call) act = ACT_CALL;
      else if (jump) act = ACT_JUMP;
      else if (adv)  act = ACT_ADV;
      else           act = ACT_HOLD;
   end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
   parameter int W     = 13,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] top
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("pc_ret_stack: DEPTH must be a power of two");
   end

   logic [W-1:0]     slot [DEPTH];
   logic [PTR_W-1:0] ptr;
   logic [PTR_W-1:0] ptr_dn;

   assign ptr_dn = ptr - 1'b1;
   assign top    = slot[ptr_dn];

   // ring buffer: pointer wraps freely, overflow overwrites oldest
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else if (push) begin
         slot[ptr] <= din;
         ptr       <= ptr + 1'b1;
      end else if (pop) begin
         ptr <= ptr_dn;
      end
   end
endmodule

// File: rtl/pc_next.sv
module pc_next
   import pc_unit_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int LOW_W      = 11,
   parameter int IMPL_WORDS = 8192,
   parameter int INT_VEC    = 4
) (
   input  pc_act_e                   act,
   input  logic [ADDR_W-1:0]         pc_q,
   input  logic [ADDR_W-1:0]         stack_top,
   input  logic [LOW_W-1:0]          tgt_low,
   input  logic [ADDR_W-LOW_W-1:0]   page_sel,
   output logic [ADDR_W-1:0]         pc_d,
   output logic [ADDR_W-1:0]         push_val,
   output logic                      push,
   output logic                      pop
);
   localparam logic [ADDR_W-1:0] IVEC = ADDR_W'(INT_VEC);

   logic [ADDR_W-1:0] inc_raw, tgt_raw, inc_w, tgt_w;

   assign inc_raw = pc_q + 1'b1;
   assign tgt_raw = {page_sel, tgt_low};

   if (IMPL_WORDS == (1 << ADDR_W)) begin : g_full
      assign inc_w = inc_raw;
      assign tgt_w = tgt_raw;
   end else begin : g_wrap
      localparam logic [ADDR_W-1:0] MASK = ADDR_W'(IMPL_WORDS - 1);
      assign inc_w = inc_raw & MASK;
      assign tgt_w = tgt_raw & MASK;
   end

   always_comb begin
      pc_d     = pc_q;
      push_val = inc_w;
      push     = 1'b0;
      pop      = 1'b0;
      unique case (act)
         ACT_IRQ:  begin pc_d = IVEC; push_val = pc_q; push = 1'b1; end
         ACT_RET:  begin pc_d = stack_top; pop = 1'b1; end
         ACT_CALL: begin pc_d = tgt_w; push = 1'b1; end
         ACT_JUMP: pc_d = tgt_w;
         ACT_ADV:  pc_d = inc_w;
         default:  pc_d = pc_q;
      endcase
   end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
   import pc_unit_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int LOW_W       = 11,
   parameter int STACK_DEPTH = 8,
   parameter int IMPL_WORDS  = 8192,
   parameter int INT_VEC     = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic                    jump,
   input  logic                    call,
   input  logic                    ret,
   input  logic                    irq,
   input  logic [LOW_W-1:0]        tgt_low,
   input  logic [ADDR_W-LOW_W-1:0] page_sel,
   output logic [ADDR_W-1:0]       pc
);
   if (IMPL_WORDS > (1 << ADDR_W) || (IMPL_WORDS & (IMPL_WORDS - 1)) != 0) begin : g_bad_size
      $error("pc_unit: IMPL_WORDS must be a power of two within the address space");
   end
   if (LOW_W >= ADDR_W) begin : g_bad_low
      $error("pc_unit: LOW_W must leave at least one page bit");
   end
   if (INT_VEC >= IMPL_WORDS) begin : g_bad_vec
      $error("pc_unit: interrupt vector outside implemented space");
   end

   pc_act_e           act;
   logic [ADDR_W-1:0] pc_q, pc_d, stack_top, push_val;
   logic              push, pop;

   pc_arbiter u_arb (
      .adv (adv), .jump (jump), .call (call), .ret (ret), .irq (irq), .act (act)
   );

   pc_next #(
      .ADDR_W (ADDR_W), .LOW_W (LOW_W), .IMPL_WORDS (IMPL_WORDS), .INT_VEC (INT_VEC)
   ) u_next (
      .act (act), .pc_q (pc_q), .stack_top (stack_top), .tgt_low (tgt_low),
      .page_sel (page_sel), .pc_d (pc_d), .push_val (push_val),
      .push (push), .pop (pop)
   );

   pc_ret_stack #(.W (ADDR_W), .DEPTH (STACK_DEPTH)) u_stack (
      .clk (clk), .rst_n (rst_n), .push (push), .pop (pop),
      .din (push_val), .top (stack_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

   assign pc = pc_q;
endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
   parameter int ADDR_W     = 13,
   parameter int LOW_W      = 11,
   parameter int IMPL_WORDS = 8192,
   parameter int INT_VEC    = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    adv,
   input logic                    jump,
   input logic                    call,
   input logic                    ret,
   input logic                    irq,
   input logic [LOW_W-1:0]        tgt_low,
   input logic [ADDR_W-LOW_W-1:0] page_sel,
   input logic [ADDR_W-1:0]       pc
);
   localparam logic [ADDR_W-1:0] MASK = ADDR_W'(IMPL_WORDS - 1);

   assert_reset_vec_R1: assert property (@(posedge clk) !rst_n |=> (pc == '0));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !jump && !call && !ret && !irq) |=> (pc == (($past(pc) + 1'b1) & MASK)));

   assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (jump && !call && !ret && !irq) |=> (pc == ({$past(page_sel), $past(tgt_low)} & MASK)));

   assert_call_tgt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (call && !ret && !irq) |=> (pc == ({$past(page_sel), $past(tgt_low)} & MASK)));

   assert_irq_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (pc == ADDR_W'(INT_VEC)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !jump && !call && !ret && !irq) |=> $stable(pc));

   assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((pc & ~MASK) == '0));
endmodule

bind pc_unit pc_unit_chk #(
   .ADDR_W (ADDR_W), .LOW_W (LOW_W), .IMPL_WORDS (IMPL_WORDS), .INT_VEC (INT_VEC)
) u_chk (
   .clk (clk), .rst_n (rst_n), .adv (adv), .jump (jump), .call (call),
   .ret (ret), .irq (irq), .tgt_low (tgt_low), .page_sel (page_sel), .pc (pc)
);

// File: tb/pc_unit_tb.sv
module pc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv = 0, jump = 0, call = 0, ret = 0, irq = 0;
   logic [10:0] tgt_low = '0;
   logic [1:0]  page_sel = '0;
   logic [12:0] pc8, pc4;

   int vectors = 0;
   int fails = 0;

   // reference state per configuration: index 0 = 8K, 1 = 4K
   logic [12:0] m_pc  [2];
   logic [12:0] m_stk [2][8];
   logic [2:0]  m_ptr [2];
   logic [12:0] m_mask [2];

   always #10 clk = ~clk;

   pc_unit u_dut (
      .clk (clk), .rst_n (rst_n), .adv (adv), .jump (jump), .call (call),
      .ret (ret), .irq (irq), .tgt_low (tgt_low), .page_sel (page_sel), .pc (pc8)
   );

   pc_unit #(.IMPL_WORDS (4096)) u_dut4k (
      .clk (clk), .rst_n (rst_n), .adv (adv), .jump (jump), .call (call),
      .ret (ret), .irq (irq), .tgt_low (tgt_low), .page_sel (page_sel), .pc (pc4)
   );

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_pc[c]  = '0;
         m_ptr[c] = '0;
         for (int i = 0; i < 8; i++) m_stk[c][i] = '0;
      end
   endtask

   task automatic model_step();
      for (int c = 0; c < 2; c++) begin
         if (irq) begin
            m_stk[c][m_ptr[c]] = m_pc[c]; m_ptr[c] = m_ptr[c] + 3'd1; m_pc[c] = 13'd4;
         end else if (ret) begin
            m_ptr[c] = m_ptr[c] - 3'd1; m_pc[c] = m_stk[c][m_ptr[c]];
         end else if (call) begin
            m_stk[c][m_ptr[c]] = (m_pc[c] + 13'd1) & m_mask[c];
            m_ptr[c] = m_ptr[c] + 3'd1;
            m_pc[c] = {page_sel, tgt_low} & m_mask[c];
         end else if (jump) begin
            m_pc[c] = {page_sel, tgt_low} & m_mask[c];
         end else if (adv) begin
            m_pc[c] = (m_pc[c] + 13'd1) & m_mask[c];
         end
      end
   endtask

   task automatic compare(input string req);
      vectors++;
      if (pc8 !== m_pc[0]) begin
         fails++;
         $display("FAIL %s 8K: pc=%h expected=%h", req, pc8, m_pc[0]);
      end
      vectors++;
      if (pc4 !== m_pc[1]) begin
         fails++;
         $display("FAIL %s 4K: pc=%h expected=%h", req, pc4, m_pc[1]);
      end
   endtask

   // one clock with given strobes; sample 1 ns after the edge
   task automatic cyc(input logic a, j, c, r, i, input logic [1:0] pg,
                      input logic [10:0] t, input string req);
      adv = a; jump = j; call = c; ret = r; irq = i; page_sel = pg; tgt_low = t;
      @(posedge clk);
      model_step();
      #1;
      adv = 0; jump = 0; call = 0; ret = 0; irq = 0;
      compare(req);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      @(posedge clk); #1;
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      m_mask[0] = 13'h1FFF;
      m_mask[1] = 13'h0FFF;
      do_reset();

      // R1: pop straight after reset yields zero from the cleared ring
      cyc(0,0,0,1,0, 2'd0, 11'd0, "R1");
      do_reset();

      // R2, R9: sequential sweep across both wrap points
      for (int k = 0; k < 8200; k++) cyc(1,0,0,0,0, 2'd0, 11'd0, "R2");

      // R3, R9: jumps into every page
      for (int pg = 0; pg < 4; pg++) begin
         cyc(0,1,0,0,0, 2'(pg), 11'h000, "R3");
         cyc(0,1,0,0,0, 2'(pg), 11'h7FF, "R9");
         cyc(0,1,0,0,0, 2'(pg), 11'h2A5, "R3");
      end

      // R4, R5, R8: nested calls ten deep, then eleven returns
      for (int d = 0; d < 10; d++) begin
         cyc(1,0,0,0,0, 2'd0, 11'd0, "R2");
         cyc(0,0,1,0,0, 2'(d), 11'(d * 97 + 5), "R4");
      end
      for (int d = 0; d < 11; d++) cyc(0,0,0,1,0, 2'd0, 11'd0, (d < 8) ? "R5" : "R8");

      // R6: interrupt inside a call, then unwind
      do_reset();
      cyc(0,1,0,0,0, 2'd3, 11'h123, "R3");
      cyc(0,0,1,0,0, 2'd1, 11'h040, "R4");
      cyc(1,0,0,0,0, 2'd0, 11'd0, "R2");
      cyc(0,0,0,0,1, 2'd0, 11'd0, "R6");
      cyc(1,0,0,0,0, 2'd0, 11'd0, "R2");
      cyc(0,0,0,1,0, 2'd0, 11'd0, "R6");
      cyc(0,0,0,1,0, 2'd0, 11'd0, "R5");

      // R7: priority combinations and hold
      cyc(1,1,1,1,1, 2'd2, 11'h300, "R7");
      cyc(1,1,1,1,0, 2'd2, 11'h300, "R7");
      cyc(1,1,1,0,0, 2'd1, 11'h155, "R7");
      cyc(1,1,0,0,0, 2'd3, 11'h0AA, "R7");
      for (int k = 0; k < 4; k++) cyc(0,0,0,0,0, 2'd0, 11'd0, "R7");
      cyc(0,0,0,1,0, 2'd0, 11'd0, "R7");
      cyc(0,0,0,1,0, 2'd0, 11'd0, "R8");

      // R8: nine interrupts overflow the ring, then drain
      do_reset();
      for (int k = 0; k < 9; k++) begin
         cyc(0,1,0,0,0, 2'(k), 11'(k * 211), "R3");
         cyc(0,0,0,0,1, 2'd0, 11'd0, "R6");
      end
      for (int k = 0; k < 10; k++) cyc(0,0,0,1,0, 2'd0, 11'd0, "R8");

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule